// File: doc/BRIEF.md
# Quarter-Rate QPSK Carrier Modulator

This block produces a self-contained QPSK test signal on a digital carrier. An internal 15-bit maximal-length shift register supplies a pseudo-random bit stream. Each pair of bits becomes one QPSK symbol. The symbol is placed on a carrier at one quarter of the sample clock. This is done by emitting four samples per symbol: the in-phase amplitude, the quadrature amplitude, and then both again negated. No multiplier and no oscillator table are used. With a 200 MHz sample clock, the carrier sits at 50 MHz.

Each clock yields one signed real sample. A strobe marks the first sample of every symbol, and the transmitted bit pair comes out alongside it, so that a downstream checker can compare against the bits it recovers. An enable pauses the stream without losing its place. A seed load restarts the sequence from a chosen register value. A build parameter exchanges the roles of the two channels for boards whose I and Q wiring is reversed.

Top module: `qpsk_qif_mod`

## Requirements
- R1: While rst_ni is low, sample_o, sym_strobe_o and sym_bits_o are zero, the phase is the I slot and the shift register holds SEED. A zero SEED is replaced by 1.
- R2: The shift register is a Fibonacci register for x^15+x^14+1. The next bit taken is state[14]; after it is taken, the state becomes {state[13:0], state[14]^state[13]}. The register state is never zero.
- R3: Each symbol consumes two consecutive stream bits. The first is the I bit and the second is the Q bit. sym_bits_o[1] is the I bit and sym_bits_o[0] is the Q bit.
- R4: A bit of 0 maps to +AMP and a bit of 1 maps to -AMP. The result is a signed two's-complement value DW bits wide, with no offset. Every sample is +AMP, -AMP or 0, and never wraps.
- R5: On consecutive enabled clocks, sample_o follows the order I, Q, -I, -Q and repeats. The output is registered, so it appears one clock after the enabled edge.
- R6: Each symbol lasts exactly four enabled clocks. sym_strobe_o is high only with the I sample and updates sym_bits_o at the same time.
- R7: If en_i is low at an edge, sample_o and sym_strobe_o go to 0 and sym_bits_o holds. The phase and the shift register hold, so the stream resumes where it stopped.
- R8: A high seed_load_i loads seed_i into the shift register, with zero forced to 1. It returns the phase to the I slot and zeroes the sample and strobe. It takes priority over en_i.
- R9: With SWAP_IQ=1, the order becomes Q, I, -Q, -I, while sym_bits_o keeps {I bit, Q bit}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Advance the stream this clock |
| seed_load_i | input | 1 | Load seed_i and restart the symbol |
| seed_i | input | 15 | Shift register seed |
| sample_o | output | DW | Signed carrier sample |
| sym_strobe_o | output | 1 | High on the I sample of each symbol |
| sym_bits_o | output | 2 | {I bit, Q bit} of the current symbol |

## Verification
A shift register that drifts from the polynomial corrupts sym_bits_o and the sample signs at the very next strobe after the fault. A phase counter that skips or stalls breaks the I, Q, -I, -Q sign pattern within one symbol, and it moves the strobe off its four-clock spacing. A pause that leaks into the state shows up at the first sample after en_i returns, as a symbol or phase that differs from the stream continued from before the pause.

// File: rtl/qif_pkg.sv
package qif_pkg;
  localparam int unsigned LFSR_W = 15;

  typedef enum logic [1:0] {
    PH_I  = 2'd0,
    PH_Q  = 2'd1,
    PH_NI = 2'd2,
    PH_NQ = 2'd3
  } qif_phase_e;

  typedef struct packed {
    logic i_bit;
    logic q_bit;
  } qif_sym_t;
endpackage

// File: rtl/qif_lfsr.sv
module qif_lfsr
  import qif_pkg::*;
#(
  parameter int unsigned W = LFSR_W,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  output qif_sym_t     pair_o
);
  localparam int unsigned TAP_HI = W - 1;
  localparam int unsigned TAP_LO = W - 2;
  localparam logic [W-1:0] RST_VAL = (SEED == '0) ? W'(1) : SEED;

  logic [W-1:0] state_q, step1, step2;

  always_comb begin
    step1 = {state_q[W-2:0], state_q[TAP_HI] ^ state_q[TAP_LO]};
    step2 = {step1[W-2:0], step1[TAP_HI] ^ step1[TAP_LO]};
  end

  assign pair_o = '{i_bit: state_q[TAP_HI], q_bit: state_q[TAP_LO]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= RST_VAL;
    else if (load_i) state_q <= (seed_i == '0) ? W'(1) : seed_i;
    else if (step_i) state_q <= step2;
  end

  assert_lfsr_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
  assert_zero_seed_forced_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && seed_i == '0) |=> state_q == W'(1));
  assert_hold_when_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(state_q));
endmodule

// File: rtl/qif_phase.sv
module qif_phase
  import qif_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adv_i,
  input  logic       clr_i,
  output qif_phase_e phase_o
);
  qif_phase_e ph_q;
  assign phase_o = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ph_q <= PH_I;
    else if (clr_i)  ph_q <= PH_I;
    else if (adv_i)  ph_q <= qif_phase_e'(ph_q + 2'd1);
  end

  assert_phase_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !clr_i) |=> $stable(ph_q));
  assert_phase_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ph_q == PH_I);
endmodule

// File: rtl/qif_mapper.sv
module qif_mapper
  import qif_pkg::*;
#(
  parameter int unsigned DW      = 12,
  parameter int unsigned AMP     = 1000,
  parameter bit          SWAP_IQ = 1'b0
) (
  input  qif_sym_t               sym_i,
  input  qif_phase_e             phase_i,
  output logic signed [DW-1:0]   sample_o
);
  localparam logic signed [DW-1:0] POS = DW'(AMP);
  localparam logic signed [DW-1:0] NEG = -POS;

  logic signed [DW-1:0] a_val, b_val;
  logic signed [DW-1:0] i_val, q_val;

  assign i_val = sym_i.i_bit ? NEG : POS;
  assign q_val = sym_i.q_bit ? NEG : POS;

  generate
    if (SWAP_IQ) begin : g_swap
      assign a_val = q_val;
      assign b_val = i_val;
    end else begin : g_direct
      assign a_val = i_val;
      assign b_val = q_val;
    end
  endgenerate

  always_comb begin
    unique case (phase_i)
      PH_I:    sample_o = a_val;
      PH_Q:    sample_o = b_val;
      PH_NI:   sample_o = -a_val;
      default: sample_o = -b_val;
    endcase
  end
endmodule

// File: rtl/qpsk_qif_mod.sv
module qpsk_qif_mod
  import qif_pkg::*;
#(
  parameter int unsigned        DW      = 12,
  parameter int unsigned        AMP     = 1000,
  parameter bit                 SWAP_IQ = 1'b0,
  parameter logic [LFSR_W-1:0]  SEED    = 15'h2A5B
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 seed_load_i,
  input  logic [LFSR_W-1:0]    seed_i,
  output logic signed [DW-1:0] sample_o,
  output logic                 sym_strobe_o,
  output logic [1:0]           sym_bits_o
);
  localparam logic signed [DW-1:0] POS = DW'(AMP);

  qif_phase_e phase;
  qif_sym_t   lfsr_pair, sym_q, cur_sym;
  logic       adv, sym_start;
  logic signed [DW-1:0] sample_d;

  assign adv       = en_i && !seed_load_i;
  assign sym_start = adv && (phase == PH_I);
  assign cur_sym   = sym_start ? lfsr_pair : sym_q;

  qif_lfsr #(.W(LFSR_W), .SEED(SEED)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (sym_start),
    .load_i (seed_load_i),
    .seed_i (seed_i),
    .pair_o (lfsr_pair)
  );

  qif_phase u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (adv),
    .clr_i   (seed_load_i),
    .phase_o (phase)
  );

  qif_mapper #(.DW(DW), .AMP(AMP), .SWAP_IQ(SWAP_IQ)) u_map (
    .sym_i    (cur_sym),
    .phase_i  (phase),
    .sample_o (sample_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_q        <= '0;
      sample_o     <= '0;
      sym_strobe_o <= 1'b0;
      sym_bits_o   <= '0;
    end else if (adv) begin
      sample_o     <= sample_d;
      sym_strobe_o <= sym_start;
      if (sym_start) begin
        sym_q      <= lfsr_pair;
        sym_bits_o <= lfsr_pair;
      end
    end else begin
      sample_o     <= '0;
      sym_strobe_o <= 1'b0;
    end
  end

  assert_sample_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o == POS) || (sample_o == -POS) || (sample_o == '0));
  assert_idle_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || seed_load_i) |=> (sample_o == '0) && !sym_strobe_o);
  assert_negated_half_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_strobe_o && adv) ##1 adv |=> sample_o == -$past(sample_o, 2));
  assert_symbol_period_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_strobe_o && adv) ##1 adv ##1 adv ##1 adv |=> sym_strobe_o);
  assert_strobe_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_strobe_o |=> !sym_strobe_o);
  assert_strobe_sign_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_strobe_o && !SWAP_IQ) |-> (sample_o[DW-1] == sym_bits_o[1]));
endmodule

// File: tb/qpsk_qif_mod_test.sv
module qpsk_qif_mod_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  localparam int AMP_A = 1000;
  localparam int AMP_B = 2047;
  localparam logic [14:0] SEED_DEF = 15'h2A5B;

  // {seed, expected first bit pair}
  localparam logic [16:0] VEC [8] = '{
    {15'h4000, 2'b10}, {15'h0001, 2'b00}, {15'h7FFF, 2'b11}, {15'h2000, 2'b01},
    {15'h5555, 2'b10}, {15'h0000, 2'b00}, {15'h3C3C, 2'b01}, {15'h6B2D, 2'b11}
  };

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, ld = 1'b0;
  logic [14:0] seed = '0;
  logic signed [DW-1:0] s_a, s_b;
  logic st_a, st_b;
  logic [1:0] bits_a, bits_b;
  int n_tests = 0, n_fail = 0;

  // bench model
  logic [14:0] m_lfsr;
  int m_ph;
  logic m_bi, m_bq;
  int e_a, e_b;
  logic e_st;

  always #(CLK_PERIOD/2) clk = ~clk;

  qpsk_qif_mod #(.DW(DW), .AMP(AMP_A), .SWAP_IQ(1'b0), .SEED(SEED_DEF)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .seed_load_i(ld), .seed_i(seed),
    .sample_o(s_a), .sym_strobe_o(st_a), .sym_bits_o(bits_a));

  qpsk_qif_mod #(.DW(DW), .AMP(AMP_B), .SWAP_IQ(1'b1), .SEED(SEED_DEF)) uut_swap (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .seed_load_i(ld), .seed_i(seed),
    .sample_o(s_b), .sym_strobe_o(st_b), .sym_bits_o(bits_b));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic take_bit();
    logic b = m_lfsr[14];
    m_lfsr = {m_lfsr[13:0], m_lfsr[14] ^ m_lfsr[13]};
    return b;
  endfunction

  function automatic int slot(input int ph, input logic x, input logic y, input int amp);
    int vx = x ? -amp : amp;
    int vy = y ? -amp : amp;
    case (ph)
      0: return vx;
      1: return vy;
      2: return -vx;
      default: return -vy;
    endcase
  endfunction

  task automatic model_step(input logic e, input logic l, input logic [14:0] sd);
    e_st = 1'b0;
    if (l) begin
      m_lfsr = (sd == 0) ? 15'd1 : sd;
      m_ph = 0; e_a = 0; e_b = 0;
    end else if (!e) begin
      e_a = 0; e_b = 0;
    end else begin
      if (m_ph == 0) begin
        m_bi = take_bit();
        m_bq = take_bit();
        e_st = 1'b1;
      end
      e_a = slot(m_ph, m_bi, m_bq, AMP_A);
      e_b = slot(m_ph, m_bq, m_bi, AMP_B);
      m_ph = (m_ph + 1) % 4;
    end
  endtask

  task automatic step(input logic e, input logic l, input logic [14:0] sd);
    en = e; ld = l; seed = sd;
    @(posedge clk);
    model_step(e, l, sd);
    @(negedge clk);
  endtask

  task automatic compare(input string req);
    check(s_a == e_a, {req, " sample"}, int'(s_a), e_a);
    check(st_a == e_st, {req, " strobe"}, int'(st_a), int'(e_st));
    check(bits_a == {m_bi, m_bq}, {req, " bits"}, int'(bits_a), int'({m_bi, m_bq}));
    check(s_b == e_b, "R9 swapped sample", int'(s_b), e_b);
    check(bits_b == {m_bi, m_bq}, "R9 swapped bits", int'(bits_b), int'({m_bi, m_bq}));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    m_lfsr = SEED_DEF; m_ph = 0; m_bi = 0; m_bq = 0; e_a = 0; e_b = 0; e_st = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(s_a == 0 && st_a == 0 && bits_a == 0, "R1 reset outputs", int'(s_a), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 first symbols come from SEED
    for (int k = 0; k < 12; k++) begin
      step(1'b1, 1'b0, '0);
      compare("R1 seeded stream");
    end
    // table: seed load then two symbols (R2 R3 R4 R5 R6 R8)
    for (int v = 0; v < 8; v++) begin
      step(1'b1, 1'b1, VEC[v][16:2]);
      check(s_a == 0 && st_a == 0, "R8 load zeroes output", int'(s_a), 0);
      step(1'b1, 1'b0, '0);
      check(bits_a == VEC[v][1:0], "R3 first pair from seed", int'(bits_a), int'(VEC[v][1:0]));
      check(st_a == 1'b1, "R6 strobe on I slot", int'(st_a), 1);
      compare("R5 table");
      for (int k = 0; k < 7; k++) begin
        step(1'b1, 1'b0, '0);
        compare("R2 stream");
      end
    end
    // R7 pause mid-symbol, then resume
    step(1'b1, 1'b1, 15'h1234);
    step(1'b1, 1'b0, '0); compare("R7 pre-pause");
    step(1'b1, 1'b0, '0); compare("R7 pre-pause");
    for (int k = 0; k < 5; k++) begin
      step(1'b0, 1'b0, '0);
      compare("R7 paused zero");
    end
    for (int k = 0; k < 10; k++) begin
      step(1'b1, 1'b0, '0);
      compare("R7 resume");
    end
    // R8 load wins over enable mid-symbol; zero seed forced to 1
    step(1'b1, 1'b0, '0);
    step(1'b1, 1'b1, 15'h0000);
    compare("R8 load priority");
    for (int k = 0; k < 8; k++) begin
      step(1'b1, 1'b0, '0);
      compare("R8 zero seed");
    end
    // R4 full-scale negation on swap instance
    step(1'b1, 1'b1, 15'h7FFF);
    step(1'b1, 1'b0, '0);
    check(s_b == -AMP_B, "R4 full scale negative", int'(s_b), -AMP_B);
    step(1'b1, 1'b0, '0);
    step(1'b1, 1'b0, '0);
    check(s_b == AMP_B, "R4 full scale positive", int'(s_b), AMP_B);
    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check(s_a == 0 && st_a == 0 && bits_a == 0, "R1 reset mid-run", int'(s_a), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule